// File: doc/BRIEF.md
# Interrupt Cause Reporting Unit

This unit sits between the master and slave engines of a two-wire serial bus controller and the processor. Each engine raises events as a small numeric cause code. The unit shows one cause at a time in a status code field and drives a single interrupt request line. Causes that arrive while another is being shown wait in a four-entry first-in first-out pending store. Software learns of a cause by watching the request line or by polling the status code. A status read takes the shown cause away, and the next waiting cause takes its place one cycle later.

Every event also carries the data byte its engine had captured. The receive-data read port returns that byte only while a master or slave receive-data cause is being shown. At all other times it returns the engine's live shift register. When the pending store is full, new events are lost and a sticky overflow flag records the loss. A status read clears the flag.

Top module: `irq_code_report`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the pending store is emptied. After that clock edge, `statusCode` is 0, `irq` is low and `statusOvf` is low.
- R2: A `statusCode` of 0 means no cause is active. `irq` is high in exactly those cycles in which `statusCode` is non-zero.
- R3: An event presented with a code of 0 is not a cause. Its valid bit has no effect on the pending store or the shown code.
- R4: An event sampled at a clock edge enters the pending store at that edge. When nothing is shown, the oldest stored event becomes the shown code at the following edge. Codes pass through unchanged, so code 1 (master lost arbitration, transfer must be repeated) is shown as 1. A shown code stays unchanged until a status read.
- R5: When the master and slave present events at the same edge, the master event is stored ahead of the slave event and is shown first.
- R6: A status read (`statusRd` high at a clock edge) while a code is shown makes `statusCode` 0 and `irq` low after that edge. A status read while nothing is shown leaves the shown code unaffected.
- R7: If a cause is waiting when the shown code is read, `irq` is low for exactly one cycle. It then rises with the waiting code.
- R8: The pending store holds 4 events besides the shown one. An event that finds no free entry is dropped, and `statusOvf` is set and stays set until a status read clears it. A drop at the same edge as a status read leaves `statusOvf` set.
- R9: Code 4'h4 is master receive-data and code 4'h8 is slave receive-data. While one of these is shown, `rxData` returns the byte that arrived with that event. Otherwise `rxData` returns `shiftLive`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mstEvtValid | input | 1 | Master engine presents an event this cycle |
| mstEvtCode | input | 4 | Master event cause code |
| mstEvtByte | input | 8 | Byte captured by the master with the event |
| slvEvtValid | input | 1 | Slave engine presents an event this cycle |
| slvEvtCode | input | 4 | Slave event cause code |
| slvEvtByte | input | 8 | Byte captured by the slave with the event |
| shiftLive | input | 8 | Live contents of the engine shift register |
| statusRd | input | 1 | Status register read strobe (read-to-clear) |
| statusCode | output | 4 | Cause code currently shown, 0 when none |
| statusOvf | output | 1 | Sticky pending-store overflow flag |
| irq | output | 1 | Interrupt request |
| rxData | output | 8 | Value returned by a receive-data register read |

## Verification
Single master events, including code 1, show the two-edge entry latency and that a shown code is held through idle cycles. Simultaneous master and slave receive-data events separate the fixed master-first order from arrival order, and show which captured byte `rxData` returns against the live shift value. Back-to-back reads with causes waiting expose the one-cycle low gap on `irq`. Filling the store, and then reading at the edge where a drop occurs, checks the drop and the set-over-clear priority of the overflow flag. A long pseudo-random mix of zero and non-zero codes, reads and a mid-run reset is compared against the reference model every cycle.

// File: rtl/irq_code_report_pkg.sv
package irq_code_report_pkg;

  localparam int CODE_W = 4;
  localparam int DATA_W = 8;

  typedef logic [CODE_W-1:0] codeT;
  typedef logic [DATA_W-1:0] byteT;

  localparam codeT CODE_NONE       = 4'h0;
  localparam codeT CODE_M_ARB_LOST = 4'h1;
  localparam codeT CODE_M_RX_DATA  = 4'h4;
  localparam codeT CODE_S_RX_DATA  = 4'h8;

  // strobes from control to datapath
  typedef struct packed {
    logic wrMst;   // store the master event
    logic wrSlv;   // store the slave event (slot after master's when both)
    logic load;    // move the oldest pending entry into the shown register
    logic clear;   // status read removes the shown cause
  } dpStrobeT;

endpackage

// File: rtl/irq_code_report_ctrl.sv
module irq_code_report_ctrl
  import irq_code_report_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     mstEvtValid,
  input  codeT     mstEvtCode,
  input  logic     slvEvtValid,
  input  codeT     slvEvtCode,
  input  logic     statusRd,
  output dpStrobeT strobe,
  output logic     curValid,
  output logic     ovfFlag
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] pendCount;
  logic [CNT_W:0]   freeSlots;
  logic             mstReq;
  logic             slvReq;
  logic             popNow;
  logic             acceptMst;
  logic             acceptSlv;
  logic             dropNow;

  always_comb begin
    // a zero code is not a cause
    mstReq    = mstEvtValid && (mstEvtCode != CODE_NONE);
    slvReq    = slvEvtValid && (slvEvtCode != CODE_NONE);
    popNow    = !curValid && (pendCount != '0);
    freeSlots = (CNT_W+1)'(DEPTH) - {1'b0, pendCount} + {{CNT_W{1'b0}}, popNow};
    acceptMst = mstReq && (freeSlots != '0);
    acceptSlv = slvReq && (acceptMst ? (freeSlots >= (CNT_W+1)'(2)) : (freeSlots != '0));
    dropNow   = (mstReq && !acceptMst) || (slvReq && !acceptSlv);
  end

  always_comb begin
    strobe.wrMst = acceptMst;
    strobe.wrSlv = acceptSlv;
    strobe.load  = popNow;
    strobe.clear = statusRd && curValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendCount <= '0;
      curValid  <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      pendCount <= pendCount + CNT_W'(acceptMst) + CNT_W'(acceptSlv) - CNT_W'(popNow);
      if (popNow)
        curValid <= 1'b1;
      else if (statusRd)
        curValid <= 1'b0;
      if (dropNow)
        ovfFlag <= 1'b1;
      else if (statusRd)
        ovfFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_code_report_dp.sv
module irq_code_report_dp
  import irq_code_report_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  dpStrobeT strobe,
  input  codeT     mstEvtCode,
  input  byteT     mstEvtByte,
  input  codeT     slvEvtCode,
  input  byteT     slvEvtByte,
  input  byteT     shiftLive,
  output codeT     shownCode,
  output byteT     rxData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  codeT             codeMem [DEPTH];
  byteT             byteMem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] slvSlot;
  byteT             shownByte;
  logic             rxCaptured;

  function automatic logic [PTR_W-1:0] incPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign slvSlot = strobe.wrMst ? incPtr(wrPtr) : wrPtr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (strobe.wrMst && (wrPtr == PTR_W'(i))) begin
        codeMem[i] <= mstEvtCode;
        byteMem[i] <= mstEvtByte;
      end else if (strobe.wrSlv && (slvSlot == PTR_W'(i))) begin
        codeMem[i] <= slvEvtCode;
        byteMem[i] <= slvEvtByte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      shownCode <= CODE_NONE;
      shownByte <= '0;
    end else begin
      if (strobe.wrMst && strobe.wrSlv)
        wrPtr <= incPtr(incPtr(wrPtr));
      else if (strobe.wrMst || strobe.wrSlv)
        wrPtr <= incPtr(wrPtr);
      if (strobe.load) begin
        rdPtr     <= incPtr(rdPtr);
        shownCode <= codeMem[rdPtr];
        shownByte <= byteMem[rdPtr];
      end else if (strobe.clear) begin
        shownCode <= CODE_NONE;
      end
    end
  end

  assign rxCaptured = (shownCode == CODE_M_RX_DATA) || (shownCode == CODE_S_RX_DATA);
  assign rxData     = rxCaptured ? shownByte : shiftLive;

endmodule

// File: rtl/irq_code_report.sv
module irq_code_report
  import irq_code_report_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mstEvtValid,
  input  logic [CODE_W-1:0] mstEvtCode,
  input  logic [DATA_W-1:0] mstEvtByte,
  input  logic              slvEvtValid,
  input  logic [CODE_W-1:0] slvEvtCode,
  input  logic [DATA_W-1:0] slvEvtByte,
  input  logic [DATA_W-1:0] shiftLive,
  input  logic              statusRd,
  output logic [CODE_W-1:0] statusCode,
  output logic              statusOvf,
  output logic              irq,
  output logic [DATA_W-1:0] rxData
);

  dpStrobeT strobe;
  logic     curValid;

  irq_code_report_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .mstEvtValid(mstEvtValid),
    .mstEvtCode (mstEvtCode),
    .slvEvtValid(slvEvtValid),
    .slvEvtCode (slvEvtCode),
    .statusRd   (statusRd),
    .strobe     (strobe),
    .curValid   (curValid),
    .ovfFlag    (statusOvf)
  );

  irq_code_report_dp #(.DEPTH(DEPTH)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .mstEvtCode(mstEvtCode),
    .mstEvtByte(mstEvtByte),
    .slvEvtCode(slvEvtCode),
    .slvEvtByte(slvEvtByte),
    .shiftLive (shiftLive),
    .shownCode (statusCode),
    .rxData    (rxData)
  );

  assign irq = curValid;

endmodule

// File: rtl/irq_code_report_chk.sv
module irq_code_report_chk
  import irq_code_report_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              statusRd,
  input logic [CODE_W-1:0] statusCode,
  input logic              statusOvf,
  input logic              irq,
  input logic [DATA_W-1:0] rxData,
  input logic [DATA_W-1:0] shiftLive
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!irq && (statusCode == CODE_NONE) && !statusOvf)); // R1

  AST_IRQ_TRACKS_CODE: assert property (@(posedge clk) disable iff (rst)
    irq == (statusCode != CODE_NONE)); // R2

  AST_SHOWN_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq && !statusRd) |=> (irq && $stable(statusCode))); // R4

  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (irq && statusRd) |=> (!irq && (statusCode == CODE_NONE))); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (statusOvf && !statusRd) |=> statusOvf); // R8

  AST_RX_LIVE_ROUTE: assert property (@(posedge clk) disable iff (rst)
    ((statusCode != CODE_M_RX_DATA) && (statusCode != CODE_S_RX_DATA)) |-> (rxData == shiftLive)); // R9

endmodule

bind irq_code_report irq_code_report_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .statusRd  (statusRd),
  .statusCode(statusCode),
  .statusOvf (statusOvf),
  .irq       (irq),
  .rxData    (rxData),
  .shiftLive (shiftLive)
);

// File: tb/irq_code_report_tb_top.sv
`timescale 1ns/1ps
module irq_code_report_tb_top;

  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mstEvtValid = 1'b0;
  logic [3:0] mstEvtCode = '0;
  logic [7:0] mstEvtByte = '0;
  logic       slvEvtValid = 1'b0;
  logic [3:0] slvEvtCode = '0;
  logic [7:0] slvEvtByte = '0;
  logic [7:0] shiftLive = '0;
  logic       statusRd = 1'b0;
  logic [3:0] statusCode;
  logic       statusOvf;
  logic       irq;
  logic [7:0] rxData;

  int checks = 0;
  int failures = 0;
  bit doneFlag = 0;

  always #2 clk = ~clk;

  irq_code_report #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst),
    .mstEvtValid(mstEvtValid), .mstEvtCode(mstEvtCode), .mstEvtByte(mstEvtByte),
    .slvEvtValid(slvEvtValid), .slvEvtCode(slvEvtCode), .slvEvtByte(slvEvtByte),
    .shiftLive(shiftLive), .statusRd(statusRd),
    .statusCode(statusCode), .statusOvf(statusOvf), .irq(irq), .rxData(rxData)
  );

  // reference model state
  logic [11:0] pendQ[$];
  bit          mCurV = 0;
  logic [3:0]  mCurC = '0;
  logic [7:0]  mCurB = '0;
  bit          mOvf = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic [3:0] eCode;
    logic [7:0] eRx;
    eCode = mCurV ? mCurC : 4'h0;
    eRx   = (mCurV && (mCurC == 4'h4 || mCurC == 4'h8)) ? mCurB : shiftLive;
    chk(tag, "statusCode", int'(statusCode), int'(eCode));
    chk(tag, "irq", int'(irq), int'(mCurV));
    chk(tag, "statusOvf", int'(statusOvf), int'(mOvf));
    chk(tag, "rxData", int'(rxData), int'(eRx));
  endtask

  // called just after a falling edge; applies inputs, advances model, compares after next rise
  task automatic step(input bit mv, input logic [3:0] mc, input logic [7:0] mb,
                      input bit sv, input logic [3:0] sc, input logic [7:0] sb,
                      input bit rd, input logic [7:0] live, input bit r, input string tag);
    bit pop;
    bit drop;
    int freeN;
    logic [11:0] ent;
    mstEvtValid = mv; mstEvtCode = mc; mstEvtByte = mb;
    slvEvtValid = sv; slvEvtCode = sc; slvEvtByte = sb;
    statusRd = rd; shiftLive = live; rst = r;
    if (r) begin
      pendQ.delete(); mCurV = 0; mCurC = '0; mCurB = '0; mOvf = 0;
    end else begin
      pop   = !mCurV && (pendQ.size() > 0);
      freeN = DEPTH - pendQ.size();
      drop  = 0;
      if (pop) begin
        ent = pendQ.pop_front();
        mCurV = 1; mCurC = ent[11:8]; mCurB = ent[7:0];
      end else if (rd && mCurV) begin
        mCurV = 0; mCurC = '0;
      end
      if (pop) freeN++;
      if (mv && mc != 0) begin
        if (freeN > 0) begin pendQ.push_back({mc, mb}); freeN--; end
        else drop = 1;
      end
      if (sv && sc != 0) begin
        if (freeN > 0) begin pendQ.push_back({sc, sb}); freeN--; end
        else drop = 1;
      end
      if (drop) mOvf = 1;
      else if (rd) mOvf = 0;
    end
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 8'h11, 0, tag);
  endtask

  task automatic readSt(input string tag);
    step(0, 0, 0, 0, 0, 0, 1, 8'h11, 0, tag);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] lfsr;
    @(negedge clk);
    step(0, 0, 0, 0, 0, 0, 0, 8'h11, 1, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 8'h11, 1, "R1");
    chk("R1", "reset code", int'(statusCode), 0);
    chk("R1", "reset irq", int'(irq), 0);
    idle(2, "R2");
    readSt("R6");                              // read with nothing shown
    chk("R6", "idle read code", int'(statusCode), 0);

    // single arbitration-lost event: two-edge latency, then held
    step(1, 4'h1, 8'h5A, 0, 0, 0, 0, 8'h11, 0, "R4");
    chk("R4", "not yet shown", int'(irq), 0);
    idle(1, "R4");
    chk("R4", "arb lost code", int'(statusCode), 1);
    chk("R9", "live route", int'(rxData), 8'h11);
    idle(3, "R4");
    readSt("R6");
    chk("R6", "cleared", int'(irq), 0);

    // code-0 events ignored
    step(1, 4'h0, 8'hFF, 1, 4'h0, 8'hEE, 0, 8'h22, 0, "R3");
    idle(3, "R3");
    chk("R3", "zero code ignored", int'(statusCode), 0);

    // simultaneous receive-data events
    step(1, 4'h4, 8'hA5, 1, 4'h8, 8'h3C, 0, 8'h11, 0, "R5");
    idle(1, "R5");
    chk("R5", "master first", int'(statusCode), 4);
    chk("R9", "captured master byte", int'(rxData), 8'hA5);
    readSt("R7");
    chk("R7", "gap low", int'(irq), 0);
    idle(1, "R7");
    chk("R7", "next shown", int'(statusCode), 8);
    chk("R9", "captured slave byte", int'(rxData), 8'h3C);
    readSt("R6");
    idle(2, "R6");

    // overflow: one shown, four pending, then one more dropped
    step(1, 4'h2, 8'h01, 0, 0, 0, 0, 8'h11, 0, "R8");
    idle(1, "R8");
    step(1, 4'h3, 8'h02, 1, 4'h5, 8'h03, 0, 8'h11, 0, "R8");
    step(1, 4'h6, 8'h04, 1, 4'h7, 8'h05, 0, 8'h11, 0, "R8");
    chk("R8", "no overflow at full", int'(statusOvf), 0);
    step(0, 0, 0, 1, 4'h9, 8'h06, 0, 8'h11, 0, "R8");
    chk("R8", "overflow set", int'(statusOvf), 1);
    idle(2, "R8");
    // read together with a drop: flag stays set
    step(1, 4'hA, 8'h07, 0, 0, 0, 1, 8'h11, 0, "R8");
    chk("R8", "set beats clear", int'(statusOvf), 1);
    idle(1, "R8");
    readSt("R8");
    chk("R8", "read clears ovf", int'(statusOvf), 0);
    for (int k = 0; k < 6; k++) begin
      idle(1, "R7");
      readSt("R7");
    end
    idle(2, "R4");

    // reset with causes pending
    step(1, 4'h4, 8'h44, 1, 4'h8, 8'h88, 0, 8'h11, 0, "R1");
    step(1, 4'h2, 8'h22, 0, 0, 0, 0, 8'h11, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 8'h11, 1, "R1");
    idle(3, "R1");
    chk("R1", "emptied by reset", int'(irq), 0);

    // pseudo-random mix
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0], lfsr[4:1], lfsr[12:5], lfsr[13] & lfsr[14], lfsr[18:15], lfsr[26:19],
           lfsr[27] & lfsr[28], lfsr[31:24], (n == 300), "R4");
    end
    idle(2, "R2");
    finishRun();
  end

endmodule